// File: doc/BRIEF.md
# Rename-Rollback Retirement Queue

This block is a circular queue that tracks instructions in program order between decode and retirement. Decode places one entry per cycle at the tail. Each entry holds the instruction's destination architectural register and the speculative rename tag that register carried before this instruction claimed it. The execution side marks an entry finished by giving its slot index. The head retires finished entries in order, up to two per cycle. Each retired entry reports its register and its old tag, so the tag can be returned to the free pool.

When speculation goes wrong, a flush names a cut slot. The queue then walks backward from its youngest entry to the cut, one slot per cycle. For each squashed entry it issues a restore request with the saved old tag. Because the newest rename is undone first, the rename map ends up as it stood before the oldest squashed instruction. At the end of the walk the tail takes the cut position. Result values and fault handling live elsewhere.

Top module: `rob_rename_rollback`

## Requirements
- R1: After synchronous reset the queue is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `flush_busy`, `commit0_valid`, `commit1_valid` and `restore_valid` are 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` high at a clock edge) stores the register and old tag in slot `alloc_idx`. It then advances `alloc_idx` by one, modulo DEPTH.
- R3: After DEPTH allocations with no retirement, `alloc_ready` is 0. A further `alloc_valid` is dropped and leaves `alloc_idx` and the stored entries unchanged.
- R4: `done_valid` sets the finished flag of slot `done_idx` only if that slot is occupied before the edge. A completion aimed at a free slot, including the slot being allocated at the same edge, has no effect.
- R5: Retirement is strictly in order from the head. The head entry retires only once its flag is set. A finished younger entry waits behind an unfinished older one.
- R6: Up to two entries retire per edge. `commit0_*` is the older one and `commit1_valid` is never high without `commit0_valid`. Commit outputs are registered and appear one cycle after the edge at which the flag is visible.
- R7: Each retirement reports, on `commitN_lreg` and `commitN_prev_vp`, the register and old tag that were stored at allocation.
- R8: A flush with an occupied cut slot raises `flush_busy` at the next edge. It then emits one restore per cycle, from the youngest entry down to the cut slot inclusive, each with that entry's register and old tag. The last restore appears in the cycle `flush_busy` falls, after which `alloc_idx` equals the cut slot.
- R9: During a flush walk and in the cycle a flush is requested, no allocation is accepted and no entry retires.
- R10: A flush whose cut slot is not occupied is ignored: `flush_busy` stays 0, no restore is issued and `alloc_idx` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Decode offers an entry |
| alloc_lreg | input | LREG_W | Destination architectural register |
| alloc_prev_vp | input | VP_W | Tag that register held before this instruction |
| alloc_ready | output | 1 | Queue can accept an entry this cycle |
| alloc_idx | output | log2(DEPTH) | Slot the next entry will occupy |
| done_valid | input | 1 | An instruction has finished |
| done_idx | input | log2(DEPTH) | Slot of the finished instruction |
| flush_valid | input | 1 | Squash request |
| flush_cut | input | log2(DEPTH) | Oldest slot to squash |
| flush_busy | output | 1 | Rollback walk in progress |
| commit0_valid | output | 1 | Older retiring entry valid |
| commit0_lreg | output | LREG_W | Its register |
| commit0_prev_vp | output | VP_W | Its old tag |
| commit1_valid | output | 1 | Younger retiring entry valid |
| commit1_lreg | output | LREG_W | Its register |
| commit1_prev_vp | output | VP_W | Its old tag |
| restore_valid | output | 1 | Rollback request valid |
| restore_lreg | output | LREG_W | Register to roll back |
| restore_prev_vp | output | VP_W | Tag to put back |

## Verification
The bound checker watches several invariants on every cycle. Occupancy never passes DEPTH, and a full or walking queue never offers `alloc_ready`. A younger retirement never appears without an older one. A retirement always follows a set head flag on a non-empty queue. Restores and retirements never overlap, and restores only follow walk cycles. The bench scenarios are needed for what depends on stored content and order: the fields reported on retirement, the youngest-first restore order, the tail landing on the cut, and completions and flushes aimed at free slots being dropped.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_BUSY = 1'b1
  } walk_state_e;

  typedef logic [1:0] retire_cnt_t;
endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                alloc_fire,
  input  rob_pkg::retire_cnt_t retire_n,
  input  logic                flush_start,
  input  logic [PTR_W-1:0]    flush_cut_ptr,
  output logic [PTR_W-1:0]    head_ptr,
  output logic [PTR_W-1:0]    tail_ptr,
  output logic [PTR_W-1:0]    occ,
  output logic                walking,
  output logic [IDX_W-1:0]    walk_idx
);
  import rob_pkg::*;

  walk_state_e      state_q;
  logic [PTR_W-1:0] head_q, tail_q, cut_q;
  logic [PTR_W-1:0] tail_dec;

  assign tail_dec = tail_q - PTR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      cut_q   <= '0;
      state_q <= WALK_IDLE;
    end else begin
      head_q <= head_q + PTR_W'(retire_n);
      case (state_q)
        WALK_IDLE: begin
          if (flush_start) begin
            state_q <= WALK_BUSY;
            cut_q   <= flush_cut_ptr;
          end else if (alloc_fire) begin
            tail_q <= tail_q + PTR_W'(1);
          end
        end
        default: begin
          tail_q <= tail_dec;
          if (tail_dec == cut_q) state_q <= WALK_IDLE;
        end
      endcase
    end
  end

  assign head_ptr = head_q;
  assign tail_ptr = tail_q;
  assign occ      = tail_q - head_q;
  assign walking  = (state_q == WALK_BUSY);
  assign walk_idx = tail_dec[IDX_W-1:0];
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH  = 16,
  parameter int LREG_W = 5,
  parameter int VP_W   = 6,
  parameter int NRD    = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LREG_W-1:0] wr_lreg,
  input  logic [VP_W-1:0]   wr_vp,
  input  logic [IDX_W-1:0]  rd_idx  [NRD],
  output logic [LREG_W-1:0] rd_lreg [NRD],
  output logic [VP_W-1:0]   rd_vp   [NRD]
);
  logic [LREG_W-1:0] lreg_mem [DEPTH];
  logic [VP_W-1:0]   vp_mem   [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      lreg_mem[wr_idx] <= wr_lreg;
      vp_mem[wr_idx]   <= wr_vp;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_lreg[p] = lreg_mem[rd_idx[p]];
    assign rd_vp[p]   = vp_mem[rd_idx[p]];
  end
endmodule

// File: rtl/rob_done_flags.sv
module rob_done_flags #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  output logic [DEPTH-1:0] flags
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
      end else if (clr_en && clr_idx == IDX_W'(i)) begin
        flags[i] <= 1'b0;
      end else if (set_en && set_idx == IDX_W'(i)) begin
        flags[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rob_rename_rollback.sv
module rob_rename_rollback #(
  parameter int DEPTH  = 16,
  parameter int LREG_W = 5,
  parameter int VP_W   = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [LREG_W-1:0] alloc_lreg,
  input  logic [VP_W-1:0]   alloc_prev_vp,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic              flush_valid,
  input  logic [IDX_W-1:0]  flush_cut,
  output logic              flush_busy,
  output logic              commit0_valid,
  output logic [LREG_W-1:0] commit0_lreg,
  output logic [VP_W-1:0]   commit0_prev_vp,
  output logic              commit1_valid,
  output logic [LREG_W-1:0] commit1_lreg,
  output logic [VP_W-1:0]   commit1_prev_vp,
  output logic              restore_valid,
  output logic [LREG_W-1:0] restore_lreg,
  output logic [VP_W-1:0]   restore_prev_vp
);
  import rob_pkg::*;

  logic [PTR_W-1:0]  head_ptr, tail_ptr, occ, cut_ptr;
  logic              walking, alloc_fire, flush_start, full;
  logic [IDX_W-1:0]  walk_idx, head_idx, head_nxt_idx, cut_off, done_off;
  logic              done_hit, ret0, ret1, may_retire;
  retire_cnt_t       retire_n;
  logic [DEPTH-1:0]  flags;
  logic [IDX_W-1:0]  rd_idx  [3];
  logic [LREG_W-1:0] rd_lreg [3];
  logic [VP_W-1:0]   rd_vp   [3];

  assign head_idx     = head_ptr[IDX_W-1:0];
  assign head_nxt_idx = head_idx + IDX_W'(1);
  assign full         = (occ == PTR_W'(DEPTH));

  assign alloc_ready = !full && !walking && !flush_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_ptr[IDX_W-1:0];
  assign flush_busy  = walking;

  // A cut slot counts only when it lies inside the occupied window.
  assign cut_off     = flush_cut - head_idx;
  assign cut_ptr     = head_ptr + PTR_W'(cut_off);
  assign flush_start = flush_valid && !walking && ({1'b0, cut_off} < occ);

  assign done_off = done_idx - head_idx;
  assign done_hit = done_valid && ({1'b0, done_off} < occ);

  assign may_retire = !walking && !flush_valid;
  assign ret0       = may_retire && (occ != '0) && flags[head_idx];
  assign ret1       = ret0 && (occ > PTR_W'(1)) && flags[head_nxt_idx];
  assign retire_n   = {ret1, ret0 ^ ret1};

  rob_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk          (clk),
    .rst          (rst),
    .alloc_fire   (alloc_fire),
    .retire_n     (retire_n),
    .flush_start  (flush_start),
    .flush_cut_ptr(cut_ptr),
    .head_ptr     (head_ptr),
    .tail_ptr     (tail_ptr),
    .occ          (occ),
    .walking      (walking),
    .walk_idx     (walk_idx)
  );

  rob_done_flags #(.DEPTH(DEPTH)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .clr_en (alloc_fire),
    .clr_idx(alloc_idx),
    .set_en (done_hit),
    .set_idx(done_idx),
    .flags  (flags)
  );

  assign rd_idx[0] = head_idx;
  assign rd_idx[1] = head_nxt_idx;
  assign rd_idx[2] = walk_idx;

  rob_entry_store #(.DEPTH(DEPTH), .LREG_W(LREG_W), .VP_W(VP_W), .NRD(3)) u_store (
    .clk    (clk),
    .wr_en  (alloc_fire),
    .wr_idx (alloc_idx),
    .wr_lreg(alloc_lreg),
    .wr_vp  (alloc_prev_vp),
    .rd_idx (rd_idx),
    .rd_lreg(rd_lreg),
    .rd_vp  (rd_vp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      commit0_valid   <= 1'b0;
      commit1_valid   <= 1'b0;
      restore_valid   <= 1'b0;
      commit0_lreg    <= '0;
      commit0_prev_vp <= '0;
      commit1_lreg    <= '0;
      commit1_prev_vp <= '0;
      restore_lreg    <= '0;
      restore_prev_vp <= '0;
    end else begin
      commit0_valid   <= ret0;
      commit1_valid   <= ret1;
      restore_valid   <= walking;
      commit0_lreg    <= rd_lreg[0];
      commit0_prev_vp <= rd_vp[0];
      commit1_lreg    <= rd_lreg[1];
      commit1_prev_vp <= rd_vp[1];
      restore_lreg    <= rd_lreg[2];
      restore_prev_vp <= rd_vp[2];
    end
  end
endmodule

// File: rtl/rob_rename_rollback_chk.sv
module rob_rename_rollback_chk #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [PTR_W-1:0] occ,
  input logic [PTR_W-1:0] head_ptr,
  input logic [DEPTH-1:0] flags,
  input logic             walking,
  input logic             alloc_ready,
  input logic             commit0_valid,
  input logic             commit1_valid,
  input logic             restore_valid
);
  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= PTR_W'(DEPTH));

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (occ == PTR_W'(DEPTH)) |-> !alloc_ready);

  assert_pair_order_R6: assert property (@(posedge clk) disable iff (rst)
    commit1_valid |-> commit0_valid);

  assert_head_finished_R5: assert property (@(posedge clk) disable iff (rst)
    commit0_valid |-> $past(flags[head_ptr[IDX_W-1:0]]));

  assert_not_empty_R5: assert property (@(posedge clk) disable iff (rst)
    commit0_valid |-> ($past(occ) != '0));

  assert_restore_from_walk_R8: assert property (@(posedge clk) disable iff (rst)
    restore_valid |-> $past(walking));

  assert_walk_no_retire_R9: assert property (@(posedge clk) disable iff (rst)
    restore_valid |-> !commit0_valid);

  assert_walk_blocks_alloc_R9: assert property (@(posedge clk) disable iff (rst)
    walking |-> !alloc_ready);
endmodule

bind rob_rename_rollback rob_rename_rollback_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .occ          (occ),
  .head_ptr     (head_ptr),
  .flags        (flags),
  .walking      (walking),
  .alloc_ready  (alloc_ready),
  .commit0_valid(commit0_valid),
  .commit1_valid(commit1_valid),
  .restore_valid(restore_valid)
);

// File: tb/tb_rob_rename_rollback.sv
`timescale 1ns/1ps
module tb_rob_rename_rollback;
  localparam int DEPTH = 16;
  localparam int IDX_W = 4;
  localparam int NV = 6;
  // {register, old tag}
  localparam logic [10:0] VEC_TAB [NV] = '{
    {5'd3, 6'd17}, {5'd9, 6'd2}, {5'd3, 6'd33},
    {5'd31, 6'd63}, {5'd0, 6'd5}, {5'd12, 6'd40}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_valid = 0, done_valid = 0, flush_valid = 0;
  logic [4:0] alloc_lreg = '0;
  logic [5:0] alloc_prev_vp = '0;
  logic [IDX_W-1:0] done_idx = '0, flush_cut = '0;
  logic alloc_ready, flush_busy, commit0_valid, commit1_valid, restore_valid;
  logic [IDX_W-1:0] alloc_idx;
  logic [4:0] commit0_lreg, commit1_lreg, restore_lreg;
  logic [5:0] commit0_prev_vp, commit1_prev_vp, restore_prev_vp;

  int n_chk = 0, n_bad = 0;
  int clog_n = 0, rlog_n = 0;
  logic [4:0] clog_l [64];
  logic [5:0] clog_v [64];
  logic [4:0] rlog_l [64];
  logic [5:0] rlog_v [64];

  always #2.5 clk = ~clk;

  rob_rename_rollback #(.DEPTH(DEPTH), .LREG_W(5), .VP_W(6)) dut (.*);

  always @(negedge clk) begin
    if (!rst) begin
      if (commit0_valid && clog_n < 64) begin
        clog_l[clog_n] = commit0_lreg; clog_v[clog_n] = commit0_prev_vp; clog_n++;
      end
      if (commit1_valid && clog_n < 64) begin
        clog_l[clog_n] = commit1_lreg; clog_v[clog_n] = commit1_prev_vp; clog_n++;
      end
      if (restore_valid && rlog_n < 64) begin
        rlog_l[rlog_n] = restore_lreg; rlog_v[rlog_n] = restore_prev_vp; rlog_n++;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 alloc_idx", alloc_idx, 0);
    chk("R1 flush_busy", flush_busy, 0);
    chk("R1 commit0_valid", commit0_valid, 0);
    chk("R1 restore_valid", restore_valid, 0);

    // R2 table allocation
    for (int i = 0; i < NV; i++) begin
      chk("R2 alloc_idx", alloc_idx, i);
      alloc_valid = 1; alloc_lreg = VEC_TAB[i][10:6]; alloc_prev_vp = VEC_TAB[i][5:0];
      tick();
    end
    alloc_valid = 0;

    // R5 younger finished first must wait
    done_valid = 1; done_idx = 1; tick(); done_valid = 0;
    repeat (3) tick();
    chk("R5 no retire behind unfinished head", clog_n, 0);
    done_valid = 1; done_idx = 0; tick(); done_valid = 0;
    tick();
    chk("R6 two retire together c0", commit0_valid, 1);
    chk("R6 two retire together c1", commit1_valid, 1);
    chk("R7 commit0_lreg", commit0_lreg, VEC_TAB[0][10:6]);
    chk("R7 commit1_prev_vp", commit1_prev_vp, VEC_TAB[1][5:0]);
    for (int i = 2; i < NV; i++) begin
      done_valid = 1; done_idx = IDX_W'(i); tick();
    end
    done_valid = 0;
    repeat (3) tick();
    chk("R5 retire count", clog_n, NV);
    for (int i = 0; i < NV; i++) begin
      chk("R5 R7 retire order lreg", clog_l[i], VEC_TAB[i][10:6]);
      chk("R7 retire old tag", clog_v[i], VEC_TAB[i][5:0]);
    end

    // R3 fill to capacity starting at slot 6
    for (int k = 0; k < DEPTH; k++) begin
      alloc_valid = 1; alloc_lreg = 5'(k + 1); alloc_prev_vp = 6'(k + 40);
      tick();
    end
    alloc_valid = 0;
    chk("R3 full blocks alloc", alloc_ready, 0);
    alloc_valid = 1; alloc_lreg = 5'd7; alloc_prev_vp = 6'd7; tick(); alloc_valid = 0;
    chk("R3 dropped alloc idx", alloc_idx, 6);

    // R8 R9 full flush at head with a completion in the request cycle
    flush_valid = 1; flush_cut = 6; done_valid = 1; done_idx = 6;
    chk("R9 no alloc in request cycle", alloc_ready, 0);
    tick();
    flush_valid = 0; done_valid = 0;
    chk("R8 busy after request", flush_busy, 1);
    chk("R9 alloc blocked in walk", alloc_ready, 0);
    repeat (DEPTH) tick();
    chk("R8 busy cleared", flush_busy, 0);
    chk("R8 tail at cut", alloc_idx, 6);
    chk("R8 ready after walk", alloc_ready, 1);
    tick();
    chk("R8 restore count", rlog_n, DEPTH);
    for (int j = 0; j < DEPTH; j++) begin
      chk("R8 restore lreg youngest first", rlog_l[j], 16 - j);
      chk("R8 restore old tag", rlog_v[j], 55 - j);
    end
    chk("R9 no retire across flush", clog_n, NV);

    // R4 completion for the slot being allocated is dropped
    alloc_valid = 1; alloc_lreg = 5'd2; alloc_prev_vp = 6'd9;
    done_valid = 1; done_idx = 6;
    tick();
    alloc_valid = 0; done_valid = 0;
    repeat (3) tick();
    chk("R4 stale completion ignored", clog_n, NV);

    // R10 flush at a free slot
    flush_valid = 1; flush_cut = 9; tick(); flush_valid = 0;
    chk("R10 busy stays low", flush_busy, 0);
    chk("R10 alloc_idx unchanged", alloc_idx, 7);
    tick();
    chk("R10 no restore", rlog_n, DEPTH);

    done_valid = 1; done_idx = 6; tick(); done_valid = 0;
    tick();
    chk("R4 valid completion retires", commit0_valid, 1);
    chk("R4 R7 retired lreg", commit0_lreg, 2);
    chk("R7 retired old tag", commit0_prev_vp, 9);

    // R8 partial flush: slots 7..10, cut at 9
    for (int k = 0; k < 4; k++) begin
      alloc_valid = 1; alloc_lreg = 5'(20 + k); alloc_prev_vp = 6'(k + 1);
      tick();
    end
    alloc_valid = 0;
    flush_valid = 1; flush_cut = 9; tick(); flush_valid = 0;
    chk("R8 partial busy", flush_busy, 1);
    chk("R8 no restore yet", restore_valid, 0);
    tick();
    chk("R8 first restore valid", restore_valid, 1);
    chk("R8 first restore lreg", restore_lreg, 23);
    chk("R8 first restore tag", restore_prev_vp, 4);
    tick();
    chk("R8 second restore lreg", restore_lreg, 22);
    chk("R8 second restore tag", restore_prev_vp, 3);
    chk("R8 busy falls with last restore", flush_busy, 0);
    tick();
    chk("R8 walk over", restore_valid, 0);
    chk("R8 tail at partial cut", alloc_idx, 9);

    done_valid = 1; done_idx = 7; tick();
    done_idx = 8; tick(); done_valid = 0;
    repeat (3) tick();
    chk("R5 survivors retire", clog_n, NV + 3);
    chk("R7 survivor lreg a", clog_l[NV + 1], 20);
    chk("R7 survivor lreg b", clog_l[NV + 2], 21);

    summary();
    $finish;
  end
endmodule